// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Tracker

This block follows the power state of a double-data-rate SDRAM device, for use in a memory controller or as a bus monitor. On every clock edge it takes the clock-enable level, the decoded command and a flag that says whether every bank is idle. From the current and the previous clock-enable sample, together with the command and the idle flag, it decides whether the device stays in normal operation or moves into, stays in or leaves one of three low-power states: self refresh, precharge power-down and active power-down.

Only when clock enable was high on the previous edge and is still high on this one does the command go on to the normal per-bank command logic, through `fwd_valid`/`fwd_cmd`. After a self-refresh exit the block runs two wait windows. In a short quiet window only deselect or NOP is allowed. A longer window, 200 edges by default, covers the DLL lock time, and reads are refused during it. Any combination that is not allowed raises a one-cycle `viol_now` and sets the sticky `viol_seen`. Only reset clears `viol_seen`.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset, `pwr_state` is 0 (normal), `viol_seen` is 0, `quiet_win` and `read_hold` are 0, and the previous clock-enable sample is taken as high.
- R2: Command codes are DESEL=0, NOP=1, ACT=2, READ=3, WRITE=4, PRE=5, AREF=6, BST=7. In state normal, with clock enable high on both the previous and the current edge and no violation, `fwd_valid` is 1 and `fwd_cmd` equals `cmd`. In every other case `fwd_valid` is 0.
- R3: State codes are 0 normal, 1 self refresh, 2 precharge power-down and 3 active power-down. In normal, clock enable going high-to-low with DESEL or NOP while `all_idle`=1 moves to state 2.
- R4: In normal, clock enable going high-to-low with DESEL or NOP while `all_idle`=0 moves to state 3.
- R5: In normal, clock enable going high-to-low with AREF while `all_idle`=1, outside the quiet window, moves to state 1.
- R6: In states 1, 2 and 3, clock enable low on the current edge keeps the state, whatever the command.
- R7: In states 1, 2 and 3, clock enable high on the current edge with DESEL or NOP returns to state 0. A command other than DESEL or NOP is a violation, and the state does not change.
- R8: A self-refresh exit at edge e opens the quiet window (`quiet_win`=1). Any command other than DESEL or NOP at edges e+1 to e+QUIET_CYC-1 is a violation. At edge e+QUIET_CYC such a command is accepted.
- R9: A READ at edges e+1 to e+LOCK_CYC-1 after a self-refresh exit is a violation, and `read_hold` is 1 during that window. A READ at edge e+LOCK_CYC is forwarded.
- R10: Every other combination in normal is a violation that leaves the state at 0. This covers a high-to-low edge with any command other than DESEL, NOP, or AREF with all banks idle, and any edge where the previous clock-enable sample was low.
- R11: A violation drives `viol_now` high for that cycle, before the edge, and sets `viol_seen` from the next edge on. `viol_seen` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable level sampled at this edge |
| cmd | input | 3 | Decoded command code |
| all_idle | input | 1 | High when every bank is precharged |
| pwr_state | output | 2 | Current power state |
| fwd_valid | output | 1 | Command handed to per-bank logic this edge |
| fwd_cmd | output | 3 | Forwarded command code |
| quiet_win | output | 1 | Self-refresh exit quiet window is active |
| read_hold | output | 1 | DLL lock window is active and reads are refused |
| viol_now | output | 1 | Violation at this edge |
| viol_seen | output | 1 | Sticky violation flag |

## Verification
The bound assertions check on every cycle that the violation flag stays sticky, that forwarding happens only on high/high edges in normal, that no read is forwarded while `read_hold` is set, and that the entry and hold transitions go to the right state. They also check that a self-refresh exit opens the lock window. Only the bench scenarios can show the exact edge at which each exit window closes, and that these edges depend on the moment of the exit. The same holds for the recovery after a rejected exit and for the agreement of long mixed sequences with an independent model.

// File: rtl/cke_pt_pkg.sv
package cke_pt_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_AREF  = 3'd6,
    CMD_BST   = 3'd7
  } dram_cmd_e;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_SELF   = 2'd1,
    PS_PD_PRE = 2'd2,
    PS_PD_ACT = 2'd3
  } pwr_state_e;

  // A command that leaves the device untouched
  function automatic logic is_quiet(input dram_cmd_e c);
    return (c == CMD_DESEL) || (c == CMD_NOP);
  endfunction

  // Power-down flavour chosen from the bank status
  function automatic pwr_state_e pd_kind(input logic idle);
    return idle ? PS_PD_PRE : PS_PD_ACT;
  endfunction

endpackage

// File: rtl/cke_edge_sampler.sv
module cke_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_q
);
  // Previous clock-enable sample; reset treats the clock as enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end
endmodule

// File: rtl/cke_countdown.sv
module cke_countdown #(
  parameter int unsigned SPAN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned EFF  = (SPAN < 1) ? 1 : SPAN;
  localparam int unsigned CW   = (EFF > 1) ? $clog2(EFF) : 1;
  localparam logic [CW-1:0] LOADV = CW'(EFF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= LOADV;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cke_state_decoder.sv
module cke_state_decoder
  import cke_pt_pkg::*;
(
  input  pwr_state_e st,
  input  logic       cke_q,
  input  logic       cke,
  input  dram_cmd_e  cmd,
  input  logic       all_idle,
  input  logic       quiet_win,
  input  logic       read_hold,
  output pwr_state_e st_nxt,
  output logic       illegal,
  output logic       pass,
  output logic       sr_exit
);
  logic quiet;
  assign quiet = is_quiet(cmd);

  always_comb begin
    st_nxt  = st;
    illegal = 1'b0;
    pass    = 1'b0;
    sr_exit = 1'b0;
    if (st == PS_NORMAL) begin
      if (!cke_q) begin
        illegal = 1'b1;
      end else if (cke) begin
        if ((quiet_win && !quiet) || (read_hold && cmd == CMD_READ)) illegal = 1'b1;
        else                                                          pass    = 1'b1;
      end else begin
        if (quiet_win && !quiet)               illegal = 1'b1;
        else if (quiet)                        st_nxt  = pd_kind(all_idle);
        else if (cmd == CMD_AREF && all_idle)  st_nxt  = PS_SELF;
        else                                   illegal = 1'b1;
      end
    end else if (cke) begin
      if (quiet) begin
        st_nxt  = PS_NORMAL;
        sr_exit = (st == PS_SELF);
      end else begin
        illegal = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_pt_pkg::*;
#(
  parameter int unsigned QUIET_CYC = 10,
  parameter int unsigned LOCK_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       all_idle,
  output logic [1:0] pwr_state,
  output logic       fwd_valid,
  output logic [2:0] fwd_cmd,
  output logic       quiet_win,
  output logic       read_hold,
  output logic       viol_now,
  output logic       viol_seen
);
  dram_cmd_e  cmd_e;
  pwr_state_e st, st_nxt;
  logic       cke_q;
  logic       illegal_w, pass_w, sr_exit_w;

  assign cmd_e = dram_cmd_e'(cmd);

  cke_edge_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cke_q(cke_q)
  );

  cke_state_decoder u_dec (
    .st(st), .cke_q(cke_q), .cke(cke), .cmd(cmd_e), .all_idle(all_idle),
    .quiet_win(quiet_win), .read_hold(read_hold),
    .st_nxt(st_nxt), .illegal(illegal_w), .pass(pass_w), .sr_exit(sr_exit_w)
  );

  cke_countdown #(.SPAN(QUIET_CYC)) u_quiet (
    .clk(clk), .rst_n(rst_n), .load(sr_exit_w), .busy(quiet_win)
  );

  cke_countdown #(.SPAN(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(sr_exit_w), .busy(read_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_NORMAL;
      viol_seen <= 1'b0;
    end else begin
      st <= st_nxt;
      if (illegal_w) viol_seen <= 1'b1;
    end
  end

  assign pwr_state = st;
  assign fwd_valid = pass_w;
  assign fwd_cmd   = pass_w ? cmd : 3'd0;
  assign viol_now  = illegal_w;
endmodule

// File: rtl/cke_power_tracker_chk.sv
module cke_power_tracker_chk #(
  parameter int unsigned LOCK_CYC = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cke_q,
  input logic [2:0] cmd,
  input logic       all_idle,
  input logic [1:0] pwr_state,
  input logic       fwd_valid,
  input logic       quiet_win,
  input logic       read_hold,
  input logic       viol_now,
  input logic       viol_seen,
  input logic       sr_exit_w
);
  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_seen |=> viol_seen);
  // R11
  viol_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> viol_seen);
  // R2
  fwd_high_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (cke && cke_q && pwr_state == 2'd0));
  // R9
  read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_hold && fwd_valid) |-> (cmd != 3'd3));
  // R3
  pd_pre_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && cke_q && !cke && cmd <= 3'd1 && all_idle) |=> pwr_state == 2'd2);
  // R5
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && cke_q && !cke && cmd == 3'd6 && all_idle && !quiet_win) |=> pwr_state == 2'd1);
  // R6
  low_power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0 && !cke) |=> $stable(pwr_state));
  // R9
  lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_w |=> (LOCK_CYC < 2 || read_hold) && pwr_state == 2'd0);
endmodule

bind cke_power_tracker cke_power_tracker_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cke_q(cke_q), .cmd(cmd),
  .all_idle(all_idle), .pwr_state(pwr_state), .fwd_valid(fwd_valid),
  .quiet_win(quiet_win), .read_hold(read_hold), .viol_now(viol_now),
  .viol_seen(viol_seen), .sr_exit_w(sr_exit_w)
);

// File: tb/tb_cke_power_tracker.sv
`timescale 1ns/1ps
module tb_cke_power_tracker;
  localparam int QW = 4;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cke;
  logic [2:0] cmd;
  logic all_idle;
  logic [1:0] pwr_state;
  logic fwd_valid;
  logic [2:0] fwd_cmd;
  logic quiet_win, read_hold, viol_now, viol_seen;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_st, m_q, m_r;
  bit m_prev, m_err;
  // values observed before the last edge
  bit o_viol, o_fwd;

  always #2.5 clk = ~clk;

  cke_power_tracker #(.QUIET_CYC(QW), .LOCK_CYC(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .all_idle(all_idle),
    .pwr_state(pwr_state), .fwd_valid(fwd_valid), .fwd_cmd(fwd_cmd),
    .quiet_win(quiet_win), .read_hold(read_hold), .viol_now(viol_now),
    .viol_seen(viol_seen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  // Reference outcome of one edge, written from the requirements
  task automatic predict(input bit ck, input int c, input bit idle,
                         output int nst, output bit ill, output bit pv, output bit srx);
    bit q;
    q = (c == 0) || (c == 1);
    nst = m_st; ill = 0; pv = 0; srx = 0;
    if (m_st != 0) begin
      if (ck && q)  begin nst = 0; srx = (m_st == 1); end
      else if (ck)  ill = 1;
    end else if (!m_prev) begin
      ill = 1;
    end else if (ck) begin
      ill = (m_q > 0 && !q) || (m_r > 0 && c == 3);
      pv  = !ill;
    end else if (m_q > 0 && !q) begin
      ill = 1;
    end else if (q) begin
      nst = idle ? 2 : 3;
    end else if (c == 6 && idle) begin
      nst = 1;
    end else begin
      ill = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cke = 1; cmd = 3'd1; all_idle = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_st = 0; m_q = 0; m_r = 0; m_prev = 1; m_err = 0;
  endtask

  task automatic step(input bit ck, input int c, input bit idle);
    int nst; bit ill, pv, srx;
    @(negedge clk);
    cke = ck; cmd = 3'(c); all_idle = idle;
    predict(ck, c, idle, nst, ill, pv, srx);
    #1;
    o_viol = viol_now; o_fwd = fwd_valid;
    chk(fwd_valid == pv, "R2 fwd_valid", fwd_valid, pv);
    chk(fwd_cmd == (pv ? 3'(c) : 3'd0), "R2 fwd_cmd", fwd_cmd, pv ? c : 0);
    chk(viol_now == ill, "R10 viol_now", viol_now, ill);
    @(posedge clk);
    if (ill) m_err = 1;
    m_st = nst;
    m_prev = ck;
    if (srx) begin m_q = QW - 1; m_r = LW - 1; end
    else begin
      if (m_q > 0) m_q--;
      if (m_r > 0) m_r--;
    end
    #1;
    chk(pwr_state == 2'(m_st), "R6 pwr_state", pwr_state, m_st);
    chk(viol_seen == m_err, "R11 viol_seen", viol_seen, m_err);
    chk(quiet_win == (m_q > 0), "R8 quiet_win", quiet_win, m_q > 0);
    chk(read_hold == (m_r > 0), "R9 read_hold", read_hold, m_r > 0);
  endtask

  initial begin
    bit ck;
    void'($urandom(32'h5eed_cafe));
    rst_n = 0; cke = 1; cmd = 3'd1; all_idle = 1;
    do_reset();
    #1;
    // R1
    chk(pwr_state == 0, "R1 state", pwr_state, 0);
    chk(viol_seen == 0, "R1 viol_seen", viol_seen, 0);
    chk(quiet_win == 0 && read_hold == 0, "R1 windows", quiet_win | read_hold, 0);

    step(1, 2, 0);
    chk(o_fwd == 1, "R2 forward ACT", o_fwd, 1);
    step(1, 1, 1);
    step(0, 1, 1);
    chk(pwr_state == 2, "R3 precharge pd", pwr_state, 2);
    step(0, 2, 1);
    chk(pwr_state == 2 && o_fwd == 0, "R6 hold pd", pwr_state, 2);
    step(1, 0, 1);
    chk(pwr_state == 0, "R7 pd exit", pwr_state, 0);
    step(1, 1, 0);
    step(0, 0, 0);
    chk(pwr_state == 3, "R4 active pd", pwr_state, 3);
    step(1, 4, 0);
    chk(o_viol == 1 && pwr_state == 3, "R7 bad exit", pwr_state, 3);
    do_reset();
    step(1, 1, 1);
    step(0, 6, 1);
    chk(pwr_state == 1, "R5 self refresh", pwr_state, 1);
    step(0, 3, 0);
    chk(pwr_state == 1, "R6 hold sr", pwr_state, 1);
    step(1, 1, 1);
    chk(pwr_state == 0 && quiet_win && read_hold, "R7 sr exit", pwr_state, 0);
    for (int i = 1; i <= QW - 2; i++) step(1, 1, 1);
    step(1, 2, 1);
    chk(o_viol == 1, "R8 early ACT", o_viol, 1);

    do_reset();
    step(1, 1, 1);
    step(0, 6, 1);
    step(1, 0, 1);
    for (int i = 1; i <= QW - 1; i++) step(1, 1, 1);
    step(1, 2, 1);
    chk(o_viol == 0 && o_fwd == 1, "R8 ACT at window end", o_viol, 0);
    for (int i = QW + 1; i <= LW - 2; i++) step(1, 0, 1);
    step(1, 3, 1);
    chk(o_viol == 1 && o_fwd == 0, "R9 early READ", o_viol, 1);
    step(1, 3, 1);
    chk(o_viol == 0 && o_fwd == 1, "R9 READ at lock end", o_viol, 0);
    step(1, 1, 1);
    chk(viol_seen == 1, "R11 sticky", viol_seen, 1);

    do_reset();
    step(0, 4, 1);
    chk(o_viol == 1 && pwr_state == 0, "R10 bad entry", pwr_state, 0);
    step(1, 1, 1);
    chk(o_viol == 1, "R10 prev low in normal", o_viol, 1);

    // constrained random with occasional resets
    do_reset();
    ck = 1;
    for (int n = 0; n < 3000; n++) begin
      int c;
      if (($urandom % 8) == 0) ck = ~ck;
      c = (($urandom % 4) != 0) ? int'($urandom % 2) : int'($urandom % 8);
      if (($urandom % 6) == 0) c = 6;
      step(ck, c, bit'($urandom % 2));
      if (n % 500 == 499) begin do_reset(); ck = 1; end
    end
    finish_run();
  end
endmodule